// File: doc/BRIEF.md
# Initial Program Load Source Responder

This block is the device-side attachment logic that answers a channel's initial program load (IPL) handshake. The channel raises an initiate request together with a two-bit status field that picks the primary or the alternate load source. It then pulses system reset twice. The device answers by raising its IPL tag, holds that tag through the second reset, and opens the storage-load path when the second reset ends.

The three channel lines are asynchronous to the device clock and can be skewed against each other, so each passes through a synchroniser. A static strap selects which status bit belongs to this device. The tag is raised from a level condition: initiate high, own status bit high, reset low, after a first reset has been seen. It is never raised from a reset edge, which makes the sequence tolerant of any arrival order among the incoming lines. A state machine tells the second reset apart from the first. Any reset that is not the second one also fires a one-cycle pulse that starts the device's ordinary reset functions.

Top module: `ipl_responder`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ipl_tag`, `cs_enable` and `rst_func` are all 0 from the next cycle.
- R2: When initiate and system reset are both high, a tag left over from an earlier load drops to 0 exactly 3 clock cycles after the later of the two lines changes, which is within 200 ns at 50 MHz. Before that it holds its old value.
- R3: The own status bit is `status_a[0]` when `strap_alt` is 0 and `status_a[1]` when `strap_alt` is 1. The tag rises only if initiate and the own bit are high and reset is low, and only after a first reset has been seen in that sequence.
- R4: With the default delay, the tag rises exactly 5 cycles after system reset falls, and never in the same cycle as the release.
- R5: Once the tag is up, a system reset arriving with initiate low (the second reset) leaves the tag at 1.
- R6: `cs_enable` rises only when the second reset falls, exactly 3 cycles after that fall, and then stays high together with the tag.
- R7: `rst_func` is a one-cycle pulse on each rising edge of system reset, except the second reset of a sequence, which produces no pulse.
- R8: A system reset with initiate low while idle gives one `rst_func` pulse and leaves `ipl_tag` and `cs_enable` at 0.
- R9: If the own status bit is 0, or initiate falls before reset releases, the tag stays 0 and the responder returns to idle.
- R10: Initiate and the own status bit held high with no reset ever seen leave the tag at 0, whether reset arrives before or after initiate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_ipl_a | input | 1 | Asynchronous initiate-load request from the channel |
| status_a | input | 2 | Asynchronous source-select status bits (bit 0 primary, bit 1 alternate) |
| sys_rst_a | input | 1 | Asynchronous channel system reset |
| strap_alt | input | 1 | Static strap: 0 primary source, 1 alternate source |
| ipl_tag | output | 1 | IPL tag driven back to the channel |
| rst_func | output | 1 | One-cycle pulse that starts the device reset functions |
| cs_enable | output | 1 | Enables the cycle-steal storage load |

## Verification
The bench sweeps both strap settings, all four status patterns and both arrival orders of initiate and reset. Each pass starts from the state the previous pass left behind, so a stale tag from a completed load has to be cleared. A design that drops the stale tag a cycle late, or one cycle early by skipping a synchroniser stage, misses the exact clear cycle. A design that keys the tag off the falling edge of reset, or that ignores the strap, raises the tag in the wrong cycle or for the wrong device. Pulse counting catches a responder that treats the second reset as an ordinary reset: it would fire an extra reset-functions pulse, drop the tag, or enable the load on the rising edge instead of the falling edge.

// File: rtl/ipl_pkg.sv
// Package: shared types for the IPL responder.
// Assumes: one-hot decoding is not needed; states are binary encoded.
package ipl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // no sequence in progress
        ST_RST1 = 3'd1,   // first reset observed together with a request
        ST_ARM  = 3'd2,   // reset released, level condition being timed
        ST_TAG  = 3'd3,   // tag raised, waiting for the second reset
        ST_RST2 = 3'd4,   // second reset active, tag held
        ST_LOAD = 3'd5    // second reset ended, storage load enabled
    } ipl_state_e;

endpackage

// File: rtl/ipl_sync.sv
// Module: multi-stage synchroniser, one chain per bit.
// Assumes: each bit is independent; the inputs change slowly relative to clk.
module ipl_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_a,
    output logic [WIDTH-1:0] q_s
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain_q [STAGES];

    // Shift each bit through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= d_a;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign q_s = chain_q[LAST];
endmodule

// File: rtl/ipl_rise.sv
// Module: rising-edge detector on an already synchronised level.
// Assumes: the input is synchronous to clk.
module ipl_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_s,
    output logic rise
);
    logic lvl_d;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl_s;
    end

    assign rise = lvl_s & ~lvl_d;
endmodule

// File: rtl/ipl_fsm.sv
// Module: sequence state machine for the IPL responder.
// Assumes: synchronised inputs; the tag is decided by levels only, and
// initiate plus reset together always restarts the sequence.
module ipl_fsm
    import ipl_pkg::*;
#(
    parameter int TAG_DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_s,
    input  logic own_s,
    input  logic srst_s,
    input  logic srst_rise,
    output logic tag,
    output logic cs_en,
    output logic rfunc
);
    localparam int CW = (TAG_DELAY > 1) ? $clog2(TAG_DELAY) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(TAG_DELAY - 1);

    ipl_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          rfunc_q;
    logic          arm_ok;

    assign arm_ok = init_s & own_s & ~srst_s;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        if (init_s && srst_s) begin
            state_d = ST_RST1;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RST1: begin
                    if (!srst_s) begin
                        if (!init_s)    state_d = ST_IDLE;
                        else if (own_s) state_d = ST_ARM;
                    end
                end
                ST_ARM: begin
                    if (!arm_ok)               state_d = ST_IDLE;
                    else if (cnt_q == CNT_LAST) state_d = ST_TAG;
                end
                ST_TAG:  if (srst_s)  state_d = ST_RST2;
                ST_RST2: if (!srst_s) state_d = ST_LOAD;
                ST_LOAD: state_d = ST_LOAD;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Delay counter that times the level condition while armed.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      cnt_q <= '0;
        else if (state_q == ST_ARM && state_d == ST_ARM) cnt_q <= cnt_q + 1'b1;
        else                                             cnt_q <= '0;
    end

    // Reset-functions pulse on every reset edge except the second reset.
    always_ff @(posedge clk) begin
        if (!rst_n) rfunc_q <= 1'b0;
        else        rfunc_q <= srst_rise && (state_q != ST_TAG);
    end

    assign tag   = (state_q == ST_TAG) || (state_q == ST_RST2) || (state_q == ST_LOAD);
    assign cs_en = (state_q == ST_LOAD);
    assign rfunc = rfunc_q;
endmodule

// File: rtl/ipl_responder.sv
// Module: top of the IPL source responder.
// Assumes: strap_alt is static; channel lines are asynchronous and skewed.
module ipl_responder #(
    parameter int SYNC_STAGES = 2,
    parameter int TAG_DELAY   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init_ipl_a,
    input  logic [1:0] status_a,
    input  logic       sys_rst_a,
    input  logic       strap_alt,
    output logic       ipl_tag,
    output logic       rst_func,
    output logic       cs_enable
);
    localparam int NIN = 4;

    logic [NIN-1:0] raw_a, raw_s;
    logic           ii_s, sr_s, own_s, sr_rise;
    logic [1:0]     st_s;

    assign raw_a = {sys_rst_a, status_a, init_ipl_a};

    ipl_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_a(raw_a), .q_s(raw_s)
    );

    assign ii_s  = raw_s[0];
    assign st_s  = raw_s[2:1];
    assign sr_s  = raw_s[3];
    assign own_s = strap_alt ? st_s[1] : st_s[0];

    ipl_rise u_rise (
        .clk(clk), .rst_n(rst_n), .lvl_s(sr_s), .rise(sr_rise)
    );

    ipl_fsm #(.TAG_DELAY(TAG_DELAY)) u_fsm (
        .clk(clk), .rst_n(rst_n), .init_s(ii_s), .own_s(own_s),
        .srst_s(sr_s), .srst_rise(sr_rise),
        .tag(ipl_tag), .cs_en(cs_enable), .rfunc(rst_func)
    );
endmodule

// File: rtl/ipl_responder_chk.sv
// Checker: temporal properties of the IPL responder, bound to the top.
module ipl_responder_chk (
    input logic clk,
    input logic rst_n,
    input logic ii_s,
    input logic sr_s,
    input logic own_s,
    input logic ipl_tag,
    input logic cs_enable,
    input logic rst_func
);
    // R2: initiate with reset clears the tag on the next cycle.
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ii_s && sr_s) |=> !ipl_tag);

    // R3 and R4: the tag rises only after a cycle of the level condition.
    p_level_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ipl_tag) |-> $past(ii_s && own_s && !sr_s));

    // R5: a reset without initiate keeps a raised tag.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ipl_tag && sr_s && !ii_s) |=> ipl_tag);

    // R6: load enable follows the fall of the second reset.
    p_cs_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_enable) |-> $past(ipl_tag && !sr_s));

    // R7: the reset-functions output is a single-cycle pulse.
    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_func |=> !rst_func);
endmodule

bind ipl_responder ipl_responder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ii_s(ii_s), .sr_s(sr_s), .own_s(own_s),
    .ipl_tag(ipl_tag), .cs_enable(cs_enable), .rst_func(rst_func)
);

// File: tb/tb_ipl_responder.sv
module tb_ipl_responder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_ipl_a = 1'b0;
    logic [1:0] status_a = 2'b00;
    logic       sys_rst_a = 1'b0;
    logic       strap_alt = 1'b0;
    logic       ipl_tag, rst_func, cs_enable;

    int vecs = 0;
    int errs = 0;
    int pcnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ipl_responder dut (
        .clk(clk), .rst_n(rst_n), .init_ipl_a(init_ipl_a), .status_a(status_a),
        .sys_rst_a(sys_rst_a), .strap_alt(strap_alt),
        .ipl_tag(ipl_tag), .rst_func(rst_func), .cs_enable(cs_enable)
    );

    always @(posedge clk) if (rst_func === 1'b1) pcnt <= pcnt + 1;

    task automatic chk(input string req, input int act, input int exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int base;
        bit prev_tag;
        bit own;
        wait_n(3);
        chk("R1 tag", ipl_tag, 0);
        chk("R1 cs", cs_enable, 0);
        chk("R1 pulse", rst_func, 0);
        rst_n = 1'b1;
        wait_n(2);
        prev_tag = 1'b0;

        for (int sa = 0; sa < 2; sa++) begin
            for (int st = 0; st < 4; st++) begin
                for (int ord = 0; ord < 2; ord++) begin
                    strap_alt = sa[0];
                    own = st[sa];
                    base = pcnt;
                    if (ord == 0) begin
                        init_ipl_a = 1'b1; status_a = st[1:0];
                        wait_n(1);
                        sys_rst_a = 1'b1;
                    end else begin
                        sys_rst_a = 1'b1;
                        wait_n(1);
                        init_ipl_a = 1'b1; status_a = st[1:0];
                    end
                    wait_n(2);
                    chk("R2 stale tag before clear", ipl_tag, prev_tag);
                    wait_n(1);
                    chk("R2 stale tag cleared", ipl_tag, 0);
                    wait_n(3);
                    chk("R10 no tag during first reset", ipl_tag, 0);
                    sys_rst_a = 1'b0;
                    wait_n(4);
                    chk("R4 tag not yet", ipl_tag, 0);
                    wait_n(1);
                    chk("R3 R4 tag after release", ipl_tag, own);
                    init_ipl_a = 1'b0; status_a = 2'b00;
                    wait_n(4);
                    chk("R9 R3 tag after initiate drop", ipl_tag, own);
                    sys_rst_a = 1'b1;
                    wait_n(6);
                    chk("R5 tag held in second reset", ipl_tag, own);
                    chk("R6 no load during second reset", cs_enable, 0);
                    sys_rst_a = 1'b0;
                    wait_n(2);
                    chk("R6 load not yet", cs_enable, 0);
                    wait_n(1);
                    chk("R6 load after second reset", cs_enable, own);
                    chk("R6 tag with load", ipl_tag, own);
                    chk("R7 R8 pulse count", pcnt - base, own ? 1 : 2);
                    prev_tag = own;
                    wait_n(2);
                end
            end
        end

        // R1: reset from the load state.
        rst_n = 1'b0;
        wait_n(1);
        chk("R1 tag after reset", ipl_tag, 0);
        chk("R1 cs after reset", cs_enable, 0);
        rst_n = 1'b1;
        wait_n(2);

        // R8: reset alone while idle.
        strap_alt = 1'b0;
        base = pcnt;
        sys_rst_a = 1'b1;
        wait_n(6);
        sys_rst_a = 1'b0;
        wait_n(8);
        chk("R8 pulse count", pcnt - base, 1);
        chk("R8 tag low", ipl_tag, 0);
        chk("R8 cs low", cs_enable, 0);

        // R10: request with own bit but no reset.
        init_ipl_a = 1'b1; status_a = 2'b11;
        wait_n(10);
        chk("R10 no tag without reset", ipl_tag, 0);

        // R9: initiate dropped while first reset still active.
        sys_rst_a = 1'b1;
        wait_n(6);
        init_ipl_a = 1'b0; status_a = 2'b00;
        wait_n(4);
        sys_rst_a = 1'b0;
        wait_n(8);
        chk("R9 no tag after aborted request", ipl_tag, 0);
        chk("R9 no load after aborted request", cs_enable, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vecs++;
            errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule